// File: doc/BRIEF.md
# Correctable Error Status Reporter

This block holds the correctable-error status word for each function on one PCI Express link. Functions with index below `NUM_PF` are physical and implement eight status bits. The remaining functions are virtual and implement only the advisory non-fatal bit. Error detectors send one-cycle pulses, each carrying an error kind. A pulse is either aimed at one function or flagged as affecting the whole link. Software clears bits by writing ones, either through the configuration write port or through the local management port. A per-function mask decides which newly set bits raise a correctable-error message request toward the root. The mask never changes what the status holds.

The message request is a single valid/ready pair shared by all functions. Everything that happens while a request is outstanding folds into that one request. When the emulation enable is high, a configuration write to the status offset sets bits instead of clearing them, so firmware can inject errors. Two resets are provided. The sticky reset clears everything. The ordinary reset spares the advisory non-fatal bit.

Top module: `cerr_status_unit`

## Requirements
- R1: After the sticky reset, every function's status (offset 0x110) and mask (offset 0x114) read 0 and `msg_valid` is low. Bits 31:16 always read 0, and any other read offset returns 0.
- R2: A function-specific pulse sets one status bit in function `evt_fn` only. The bit is chosen by `evt_kind` as follows: 0 gives bit 0, 1 gives bit 6, 2 gives bit 7, 3 gives bit 8, 4 gives bit 12, 5 gives bit 13, 6 gives bit 14 and 7 gives bit 15. The new value reads back on the clock edge that samples the pulse.
- R3: A pulse with `evt_link` high sets its bit in every function that implements that bit, whatever `evt_fn` holds. It raises at most one message request.
- R4: A virtual function implements only bit 13 (status mask 0x2000). Events, writes and emulation writes aimed at any of its other status or mask bits leave them reading 0.
- R5: When `emu_en` is low, writing a 1 to an implemented status bit clears it. This works through the configuration port (offset 0x110) and through the management port. Writing a 0 leaves the bit unchanged.
- R6: Mask bits, written at offset 0x114, never alter status. A bit that rises while its mask bit is 1 raises no message request.
- R7: A message request is raised only when an implemented, unmasked status bit goes from 0 to 1. Setting a bit that is already set raises nothing.
- R8: `msg_valid` stays high until a cycle with `msg_ready` high. Rises that occur while it is pending, including in the accepting cycle, merge into one request: in the accepting cycle `msg_valid` stays high only if a new rise happens in that same cycle.
- R9: If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: When `emu_en` is high, a configuration write to offset 0x110 sets each implemented bit written as 1 and clears nothing. These sets follow the same mask and message rules as detected errors.
- R11: The ordinary reset clears every status bit except bit 13, clears all masks and drops `msg_valid`. The sticky reset clears bit 13 as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Ordinary synchronous reset, active low; spares bit 13 |
| sticky_rst_n | input | 1 | Sticky synchronous reset, active low; clears all state |
| evt_valid | input | 1 | One-cycle error detection pulse |
| evt_kind | input | 3 | Error kind, mapped to a status bit as in R2 |
| evt_link | input | 1 | Error is link-wide rather than function-specific |
| evt_fn | input | FW | Target function of a function-specific error |
| emu_en | input | 1 | Emulation enable: configuration status writes set bits |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_fn | input | FW | Function addressed by the configuration write |
| cfg_addr | input | 12 | Configuration write offset |
| cfg_wdata | input | 32 | Configuration write data |
| mg_wr | input | 1 | Management clear strobe (write-one-to-clear of status) |
| mg_fn | input | FW | Function addressed by the management write |
| mg_wdata | input | 32 | Management write data |
| rd_fn | input | FW | Function selected for readback |
| rd_addr | input | 12 | Readback offset |
| rd_data | output | 32 | Combinational readback of status or mask |
| msg_valid | output | 1 | Correctable-error message request pending |
| msg_ready | input | 1 | Acceptance of the message request |

## Verification
The bench targets the cycle where an event and a clear hit the same bit. A design that let the clear win would read the bit as 0 there. Link-wide pulses are checked in every function, so a design that updated only `evt_fn`, or that set bits a virtual function lacks, gives a wrong readback somewhere. The message handshake is tested with ready held low through several events and then with a new rise in the accepting cycle. A design that queued requests would show an extra pulse, and one that dropped same-cycle rises would show a missing pulse. Both resets are applied after state has built up, which exposes a bit 13 that is not sticky or a mask that survives the ordinary reset.

// File: rtl/cerr_status_unit.sv
`timescale 1ns/1ps
module cerr_status_unit #(
  parameter int NUM_FN = 4,
  parameter int NUM_PF = 2,
  parameter logic [11:0] STAT_ADDR = 12'h110,
  parameter logic [11:0] MASK_ADDR = 12'h114,
  localparam int FW = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sticky_rst_n,
  input  logic          evt_valid,
  input  logic [2:0]    evt_kind,
  input  logic          evt_link,
  input  logic [FW-1:0] evt_fn,
  input  logic          emu_en,
  input  logic          cfg_wr,
  input  logic [FW-1:0] cfg_fn,
  input  logic [11:0]   cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          mg_wr,
  input  logic [FW-1:0] mg_fn,
  input  logic [31:0]   mg_wdata,
  input  logic [FW-1:0] rd_fn,
  input  logic [11:0]   rd_addr,
  output logic [31:0]   rd_data,
  output logic          msg_valid,
  input  logic          msg_ready
);
  localparam logic [15:0] PF_BITS = 16'hF1C1;
  localparam logic [15:0] VF_BITS = 16'h2000;
  localparam logic [15:0] STICKY  = 16'h2000;

  logic [15:0] stat_q [NUM_FN];
  logic [15:0] mask_q [NUM_FN];
  logic [NUM_FN-1:0] rise;

  function automatic logic [15:0] kind_bit(input logic [2:0] k);
    case (k)
      3'd0: kind_bit = 16'h0001;
      3'd1: kind_bit = 16'h0040;
      3'd2: kind_bit = 16'h0080;
      3'd3: kind_bit = 16'h0100;
      3'd4: kind_bit = 16'h1000;
      3'd5: kind_bit = 16'h2000;
      3'd6: kind_bit = 16'h4000;
      default: kind_bit = 16'h8000;
    endcase
  endfunction

  wire stat_wr = cfg_wr && (cfg_addr == STAT_ADDR);
  wire mask_wr = cfg_wr && (cfg_addr == MASK_ADDR);
  wire [15:0] evt_bit = kind_bit(evt_kind);

  for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
    localparam logic [15:0] IMPL = (f < NUM_PF) ? PF_BITS : VF_BITS;
    wire hit   = evt_valid && (evt_link || int'(evt_fn) == f);
    wire cfg_f = int'(cfg_fn) == f;
    wire mg_f  = mg_wr && int'(mg_fn) == f;
    wire [15:0] set_v = ((hit ? evt_bit : 16'h0) |
                         ((stat_wr && cfg_f && emu_en) ? cfg_wdata[15:0] : 16'h0)) & IMPL;
    wire [15:0] clr_v = (((stat_wr && cfg_f && !emu_en) ? cfg_wdata[15:0] : 16'h0) |
                         (mg_f ? mg_wdata[15:0] : 16'h0)) & IMPL;

    assign rise[f] = |(set_v & ~stat_q[f] & ~mask_q[f]);

    always_ff @(posedge clk) begin
      if (!sticky_rst_n)   stat_q[f] <= '0;
      else if (!rst_n)     stat_q[f] <= stat_q[f] & STICKY;
      else                 stat_q[f] <= (stat_q[f] & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
      if (!sticky_rst_n || !rst_n)  mask_q[f] <= '0;
      else if (mask_wr && cfg_f)    mask_q[f] <= cfg_wdata[15:0] & IMPL;
    end
  end

  always_ff @(posedge clk) begin
    if (!sticky_rst_n || !rst_n) msg_valid <= 1'b0;
    else                         msg_valid <= (|rise) | (msg_valid & ~msg_ready);
  end

  wire rd_ok = int'(rd_fn) < NUM_FN;
  always_comb begin
    rd_data = '0;
    if (rd_ok && rd_addr == STAT_ADDR) rd_data[15:0] = stat_q[rd_fn];
    else if (rd_ok && rd_addr == MASK_ADDR) rd_data[15:0] = mask_q[rd_fn];
  end
endmodule

// File: rtl/cerr_status_chk.sv
`timescale 1ns/1ps
module cerr_status_chk #(
  parameter int NUM_FN = 4,
  parameter int NUM_PF = 2,
  parameter logic [11:0] STAT_ADDR = 12'h110,
  localparam int FW = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sticky_rst_n,
  input logic          evt_valid,
  input logic          emu_en,
  input logic          cfg_wr,
  input logic          mg_wr,
  input logic [FW-1:0] rd_fn,
  input logic [11:0]   rd_addr,
  input logic [31:0]   rd_data,
  input logic          msg_valid,
  input logic          msg_ready
);
  wire rst_any = !rst_n || !sticky_rst_n;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst_any)
    rd_data[31:16] == 16'h0); // R1

  AST_VF_HARDWIRE: assert property (@(posedge clk) disable iff (rst_any)
    (int'(rd_fn) >= NUM_PF && rd_addr == STAT_ADDR) |-> ((rd_data & ~32'h2000) == 32'h0)); // R4

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst_any)
    (msg_valid && !msg_ready) |=> msg_valid); // R8

  AST_NO_SPURIOUS_MSG: assert property (@(posedge clk) disable iff (rst_any)
    $rose(msg_valid) |-> $past(evt_valid || (cfg_wr && emu_en))); // R7

  AST_STAT_PERSIST: assert property (@(posedge clk) disable iff (rst_any)
    (rd_addr == STAT_ADDR && !cfg_wr && !mg_wr) |=>
      (rd_addr != STAT_ADDR || !$stable(rd_fn) || (($past(rd_data) & ~rd_data) == 32'h0))); // R5
endmodule

bind cerr_status_unit cerr_status_chk #(
  .NUM_FN(NUM_FN), .NUM_PF(NUM_PF), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sticky_rst_n(sticky_rst_n), .evt_valid(evt_valid),
  .emu_en(emu_en), .cfg_wr(cfg_wr), .mg_wr(mg_wr), .rd_fn(rd_fn), .rd_addr(rd_addr),
  .rd_data(rd_data), .msg_valid(msg_valid), .msg_ready(msg_ready)
);

// File: tb/sim_cerr_status_unit.sv
`timescale 1ns/1ps
module sim_cerr_status_unit;
  localparam int NF = 4;
  localparam int NP = 2;
  localparam int FW = 2;
  localparam logic [11:0] SA = 12'h110;
  localparam logic [11:0] MA = 12'h114;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n = 0, sticky_rst_n = 0;
  logic evt_valid = 0, evt_link = 0, emu_en = 0, cfg_wr = 0, mg_wr = 0, msg_ready = 0;
  logic [2:0] evt_kind = 0;
  logic [FW-1:0] evt_fn = 0, cfg_fn = 0, mg_fn = 0, rd_fn = 0;
  logic [11:0] cfg_addr = 0, rd_addr = 0;
  logic [31:0] cfg_wdata = 0, mg_wdata = 0, rd_data;
  logic msg_valid;

  cerr_status_unit #(.NUM_FN(NF), .NUM_PF(NP)) u0 (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] m_stat [NF];
  logic [15:0] m_mask [NF];
  logic m_msg;

  function automatic int kpos(input logic [2:0] k);
    int p [8] = '{0, 6, 7, 8, 12, 13, 14, 15};
    return p[k];
  endfunction

  function automatic void model();
    logic any = 0;
    for (int f = 0; f < NF; f++) begin
      logic [15:0] impl = (f < NP) ? 16'hF1C1 : 16'h2000;
      logic [15:0] s = 0, c = 0;
      if (!sticky_rst_n) begin m_stat[f] = 0; m_mask[f] = 0; end
      else if (!rst_n) begin m_stat[f] &= 16'h2000; m_mask[f] = 0; end
      else begin
        if (evt_valid && (evt_link || int'(evt_fn) == f)) s[kpos(evt_kind)] = 1'b1;
        if (cfg_wr && int'(cfg_fn) == f && cfg_addr == SA) begin
          if (emu_en) s |= cfg_wdata[15:0]; else c |= cfg_wdata[15:0];
        end
        if (mg_wr && int'(mg_fn) == f) c |= mg_wdata[15:0];
        s &= impl; c &= impl;
        if ((s & ~m_stat[f] & ~m_mask[f]) != 0) any = 1;
        m_stat[f] = (m_stat[f] & ~c) | s;
        if (cfg_wr && int'(cfg_fn) == f && cfg_addr == MA) m_mask[f] = cfg_wdata[15:0] & impl;
      end
    end
    if (!sticky_rst_n || !rst_n) m_msg = 0;
    else m_msg = any | (m_msg & ~msg_ready);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "msg_valid", {31'b0, msg_valid}, {31'b0, m_msg});
    for (int f = 0; f < NF; f++) begin
      rd_fn = FW'(f); rd_addr = SA; #0.1;
      chk(tag, $sformatf("status fn%0d", f), rd_data, {16'h0, m_stat[f]});
      rd_addr = MA; #0.1;
      chk(tag, $sformatf("mask fn%0d", f), rd_data, {16'h0, m_mask[f]});
    end
  endtask

  task automatic idle();
    evt_valid = 0; evt_link = 0; cfg_wr = 0; mg_wr = 0; emu_en = 0; msg_ready = 0;
    cfg_wdata = 0; mg_wdata = 0; cfg_addr = 0;
  endtask

  task automatic cyc(input string tag);
    model();
    @(posedge clk); @(negedge clk);
    check_all(tag);
    idle();
  endtask

  task automatic ev(input int f, input int k, input bit link);
    evt_valid = 1; evt_fn = FW'(f); evt_kind = 3'(k); evt_link = link;
  endtask

  task automatic cw(input int f, input logic [11:0] a, input logic [31:0] d);
    cfg_wr = 1; cfg_fn = FW'(f); cfg_addr = a; cfg_wdata = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int f = 0; f < NF; f++) begin m_stat[f] = 0; m_mask[f] = 0; end
    m_msg = 0;
    @(negedge clk); cyc("R1"); cyc("R1");
    sticky_rst_n = 1; rst_n = 1;
    @(negedge clk);
    check_all("R1");
    rd_addr = 12'h118; #0.1; chk("R1", "unmapped read", rd_data, 32'h0);

    // R2: function-specific pulse, fn1 kind1 -> bit 6
    ev(1, 1, 0); cyc("R2");
    ev(0, 7, 0); cyc("R2");
    // R8: ready low, events keep merging into one pending request
    ev(0, 0, 0); cyc("R8");
    ev(1, 4, 0); cyc("R8");
    msg_ready = 1; cyc("R8");
    cyc("R8");
    // R7: already-set bit raises nothing
    ev(1, 1, 0); cyc("R7");
    // R5: write 0 keeps, write 1 clears; management clear
    cw(1, SA, 32'h0); cyc("R5");
    cw(1, SA, 32'h40); cyc("R5");
    mg_wr = 1; mg_fn = 0; mg_wdata = 32'h0001; cyc("R5");
    // R6: masked rise sets status but no request
    cw(0, MA, 32'h1000); cyc("R6");
    ev(0, 4, 0); cyc("R6");
    // R3: link-wide advisory reaches every function, one request
    ev(2, 5, 1); cyc("R3");
    msg_ready = 1; cyc("R3");
    ev(3, 0, 1); cyc("R3");
    msg_ready = 1; cyc("R3");
    // R4: virtual function hardwiring
    ev(3, 2, 0); cyc("R4");
    cw(3, MA, 32'hFFFF_FFFF); cyc("R4");
    emu_en = 1; cw(2, SA, 32'hFFFF); cyc("R4");
    // R9: set wins over a same-cycle clear
    cw(2, SA, 32'h2000); ev(2, 5, 0); cyc("R9");
    mg_wr = 1; mg_fn = 0; mg_wdata = 32'h0080; ev(0, 2, 0); cyc("R9");
    msg_ready = 1; cyc("R9");
    // R10: emulation sets, never clears, follows message rules
    emu_en = 1; cw(0, SA, 32'h0100); cyc("R10");
    msg_ready = 1; cyc("R10");
    emu_en = 1; cw(0, SA, 32'h0100); cyc("R10");
    // R8: a new rise in the accepting cycle keeps the request up
    ev(1, 6, 0); cyc("R8");
    msg_ready = 1; ev(1, 3, 0); cyc("R8");
    msg_ready = 1; cyc("R8");
    // R11: ordinary reset spares bit 13, sticky reset clears it
    cw(1, MA, 32'h0040); cyc("R11");
    ev(0, 0, 0); cyc("R11");
    rst_n = 0; cyc("R11");
    rst_n = 1; @(negedge clk); check_all("R11");
    sticky_rst_n = 0; cyc("R11");
    sticky_rst_n = 1; @(negedge clk); check_all("R11");

    // random traffic covering R2 R3 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 600; i++) begin
      int a;
      if ($urandom_range(99) < 35) ev($urandom_range(NF-1), $urandom_range(7), $urandom_range(9) < 2);
      if ($urandom_range(99) < 25) begin
        a = $urandom_range(2);
        cw($urandom_range(NF-1), a == 0 ? SA : (a == 1 ? MA : 12'h118),
           ($urandom_range(1) == 0) ? $urandom : (32'h1 << $urandom_range(15)));
      end
      if ($urandom_range(99) < 15) begin
        mg_wr = 1; mg_fn = FW'($urandom_range(NF-1)); mg_wdata = $urandom;
      end
      emu_en = $urandom_range(99) < 20;
      msg_ready = $urandom_range(1);
      cyc("RND R2 R5 R6 R7 R8 R10");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule